// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Interface

This block is the byte-wide register file of a SCSI bus controller, as seen by a host processor. The host reaches sixteen register offsets through a byte address. That address is shifted right by `ADDR_SHIFT` before it is decoded, so the registers can sit on a wider bus stride. At several offsets the byte the host writes lands in a different register from the byte the host reads. For example, the offset that reads back the controller status takes the target bus identifier when written. The block holds the status, interrupt-reason, sequence-step, FIFO-flags, transfer-count and configuration registers.

A write to the command offset is decoded on the spot. The commands in scope update status, interrupt reason, sequence step and flags. Two of them assert the level interrupt output `irq`, which always equals status bit 7. Reading the interrupt-reason register hands back its value and acknowledges the interrupt in the same access. Selection, data movement and the targets are handled elsewhere. The codes for those operations are accepted here without any effect.

Register access uses single-cycle strobes. The block never stalls the host, so there is no back-pressure. Read data appears on `rd_data` in the cycle after `rd_en`. A read and a write must not be issued in the same cycle.

Top module: `ctl_regif`

## Requirements
- R1: After reset, offset 0xE reads 0x04 (chip identifier) and offset 0x8 reads 0x07. Every other offset reads 0x00, and `irq` and `dma_mode` are low.
- R2: The register offset is `addr >> ADDR_SHIFT`. The low `ADDR_SHIFT` address bits have no effect.
- R3: Writes to offsets 0x4–0x7, 0x9 and 0xA do not change what those offsets read back. Writes to offsets 0x0 and 0x1 (count low/mid) change their read copies only through the DMA command qualifier.
- R4: A read of offset 0x5 returns its previous value. In the same access it zeroes offset 0x5, clears status bits 4 and 7, sets the sequence step (offset 0x6) to 4 and drops `irq`.
- R5: A recognised command written with bit 7 set drives `dma_mode` high and copies the written count low/mid bytes into offsets 0x0/0x1. A recognised command written with bit 7 clear drives `dma_mode` low and leaves those copies alone.
- R6: A write to offset 0x0 or 0x1 clears status bit 4.
- R7: Command 0x03 sets the interrupt reason to 0x80. It raises `irq` only when bit 6 of the last byte written to offset 0x8 is 0.
- R8: Command 0x01 sets the interrupt reason to 0x08, zeroes the sequence step and the flags, and leaves `irq` unchanged.
- R9: Command 0x18 sets the low seven status bits to 0x10 and keeps status bit 7. It also sets the interrupt reason to 0x08 and the sequence step to 0.
- R10: Command 0x12 sets the interrupt reason to 0x20, zeroes the sequence step and the flags, and sets status bit 7, raising `irq`. `irq` rises only on commands 0x03 and 0x12.
- R11: Command 0x44 zeroes the interrupt reason. Command 0x02 returns every register to its R1 value and drops `irq` and `dma_mode`.
- R12: A command whose low seven bits are none of 0x00, 0x01, 0x02, 0x03, 0x10, 0x11, 0x12, 0x18, 0x1A, 0x41, 0x42, 0x43 or 0x44 changes only the offset 0x3 read-back. It pulses `cmd_err` for one cycle. The codes 0x00, 0x10, 0x11, 0x1A, 0x41, 0x42 and 0x43 do nothing here beyond R5 and raise no error.
- R13: Offsets 0x3, 0x8 and 0xB–0xF read back the last byte written to them.
- R14: `rd_data` carries the addressed register one cycle after `rd_en`. `irq` is a level equal to status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 4+ADDR_SHIFT | Byte address; offset is addr >> ADDR_SHIFT |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid the cycle after rd_en |
| irq | output | 1 | Level interrupt request |
| dma_mode | output | 1 | Last recognised command carried the DMA qualifier |
| cmd_err | output | 1 | One-cycle pulse for an unrecognised command code |

## Verification
The bench builds the block with `ADDR_SHIFT` = 2, so the bus address is six bits wide and two low bits are ignored. On every access it rotates those two junk bits through all four values. This exposes any decode that reads the low bits instead of shifting them out. Back-to-back commands stack interrupt causes: a pad after message-accepted, and enable-selection on a pending interrupt. These show that status bit 7 survives the status rewrite and is cleared only by the destructive read.

// File: rtl/ctl_regs_pkg.sv
package ctl_regs_pkg;
  localparam int NUM_REGS = 16;
  localparam int OFF_W    = 4;

  localparam logic [OFF_W-1:0] OFF_CNT_LO  = 4'h0;
  localparam logic [OFF_W-1:0] OFF_CNT_MID = 4'h1;
  localparam logic [OFF_W-1:0] OFF_CMD     = 4'h3;
  localparam logic [OFF_W-1:0] OFF_STAT    = 4'h4;
  localparam logic [OFF_W-1:0] OFF_INTR    = 4'h5;
  localparam logic [OFF_W-1:0] OFF_SEQ     = 4'h6;
  localparam logic [OFF_W-1:0] OFF_FLAG    = 4'h7;
  localparam logic [OFF_W-1:0] OFF_CFG1    = 4'h8;
  localparam logic [OFF_W-1:0] OFF_CNT_HI  = 4'hE;

  localparam logic [7:0] CHIP_ID   = 8'h04;
  localparam logic [7:0] CFG1_INIT = 8'h07;
  localparam logic [7:0] SEQ_DONE  = 8'h04;
  localparam int         STAT_TC_BIT  = 4;
  localparam int         STAT_IRQ_BIT = 7;
  localparam int         CFG1_MUTE_BIT = 6;

  localparam logic [7:0] WHY_FUNC_DONE = 8'h08;
  localparam logic [7:0] WHY_DISCONN   = 8'h20;
  localparam logic [7:0] WHY_BUS_RST   = 8'h80;

  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_RESET   = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_XFER    = 7'h10;
  localparam logic [6:0] OP_CMPL    = 7'h11;
  localparam logic [6:0] OP_MSGACC  = 7'h12;
  localparam logic [6:0] OP_PAD     = 7'h18;
  localparam logic [6:0] OP_SETATN  = 7'h1A;
  localparam logic [6:0] OP_SEL     = 7'h41;
  localparam logic [6:0] OP_SEL_A   = 7'h42;
  localparam logic [6:0] OP_SEL_AS  = 7'h43;
  localparam logic [6:0] OP_RESEL   = 7'h44;

  typedef struct packed {
    logic dma;
    logic soft_rst;
    logic flush;
    logic bus_rst;
    logic msg_acc;
    logic pad;
    logic resel_en;
    logic unknown;
  } cmd_act_t;
endpackage

// File: rtl/ctl_addr_dec.sv
module ctl_addr_dec
  import ctl_regs_pkg::*;
#(
  parameter int ADDR_SHIFT = 2,
  localparam int BUS_AW = OFF_W + ADDR_SHIFT
) (
  input  logic [BUS_AW-1:0] addr,
  output logic [OFF_W-1:0]  off,
  output logic              mirror_hit,
  output logic              cnt_hit
);
  assign off        = OFF_W'(addr >> ADDR_SHIFT);
  // offsets whose written byte also becomes the readable byte
  assign mirror_hit = (off == OFF_CFG1) || (off >= 4'hB);
  assign cnt_hit    = (off == OFF_CNT_LO) || (off == OFF_CNT_MID);
endmodule

// File: rtl/ctl_cmd_dec.sv
module ctl_cmd_dec
  import ctl_regs_pkg::*;
(
  input  logic [7:0] code,
  output cmd_act_t   act
);
  always_comb begin
    act     = '0;
    act.dma = code[7];
    unique case (code[6:0])
      OP_FLUSH:  act.flush    = 1'b1;
      OP_RESET:  act.soft_rst = 1'b1;
      OP_BUSRST: act.bus_rst  = 1'b1;
      OP_MSGACC: act.msg_acc  = 1'b1;
      OP_PAD:    act.pad      = 1'b1;
      OP_RESEL:  act.resel_en = 1'b1;
      OP_NOP, OP_XFER, OP_CMPL, OP_SETATN,
      OP_SEL, OP_SEL_A, OP_SEL_AS: ;
      default:   act.unknown  = 1'b1;
    endcase
  end
endmodule

// File: rtl/ctl_regif.sv
module ctl_regif
  import ctl_regs_pkg::*;
#(
  parameter int ADDR_SHIFT = 2,
  localparam int BUS_AW = OFF_W + ADDR_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              irq,
  output logic              dma_mode,
  output logic              cmd_err
);
  logic [7:0]       rd_q [NUM_REGS];
  logic [7:0]       wr_q [NUM_REGS];
  logic [7:0]       rd_data_q;
  logic             dma_q;
  logic             err_q;
  logic [OFF_W-1:0] off;
  logic             mirror_hit;
  logic             cnt_hit;
  cmd_act_t         act;
  logic             cmd_wr;
  logic             soft_rst;

  ctl_addr_dec #(.ADDR_SHIFT(ADDR_SHIFT)) u_addr (
    .addr       (addr),
    .off        (off),
    .mirror_hit (mirror_hit),
    .cnt_hit    (cnt_hit)
  );

  ctl_cmd_dec u_cmd (
    .code (wr_data),
    .act  (act)
  );

  assign cmd_wr   = wr_en && (off == OFF_CMD);
  assign soft_rst = cmd_wr && act.soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        rd_q[i] <= 8'h00;
        wr_q[i] <= 8'h00;
      end
      rd_q[OFF_CFG1]   <= CFG1_INIT;
      rd_q[OFF_CNT_HI] <= CHIP_ID;
      rd_data_q        <= 8'h00;
      dma_q            <= 1'b0;
      err_q            <= 1'b0;
    end else begin
      err_q <= 1'b0;
      // host read, interrupt-reason read acknowledges
      if (rd_en) begin
        rd_data_q <= rd_q[off];
        if (off == OFF_INTR) begin
          rd_q[OFF_INTR]               <= 8'h00;
          rd_q[OFF_STAT][STAT_TC_BIT]  <= 1'b0;
          rd_q[OFF_STAT][STAT_IRQ_BIT] <= 1'b0;
          rd_q[OFF_SEQ]                <= SEQ_DONE;
        end
      end
      if (wr_en) begin
        wr_q[off] <= wr_data;
        if (mirror_hit) rd_q[off] <= wr_data;
        if (cnt_hit)    rd_q[OFF_STAT][STAT_TC_BIT] <= 1'b0;
      end
      if (cmd_wr) begin
        rd_q[OFF_CMD] <= wr_data;
        err_q         <= act.unknown;
        if (!act.unknown) begin
          dma_q <= act.dma;
          if (act.dma) begin
            rd_q[OFF_CNT_LO]  <= wr_q[OFF_CNT_LO];
            rd_q[OFF_CNT_MID] <= wr_q[OFF_CNT_MID];
          end
          if (act.flush) begin
            rd_q[OFF_INTR] <= WHY_FUNC_DONE;
            rd_q[OFF_SEQ]  <= 8'h00;
            rd_q[OFF_FLAG] <= 8'h00;
          end
          if (act.bus_rst) begin
            rd_q[OFF_INTR] <= WHY_BUS_RST;
            if (!wr_q[OFF_CFG1][CFG1_MUTE_BIT])
              rd_q[OFF_STAT][STAT_IRQ_BIT] <= 1'b1;
          end
          if (act.msg_acc) begin
            rd_q[OFF_INTR]               <= WHY_DISCONN;
            rd_q[OFF_SEQ]                <= 8'h00;
            rd_q[OFF_FLAG]               <= 8'h00;
            rd_q[OFF_STAT][STAT_IRQ_BIT] <= 1'b1;
          end
          if (act.pad) begin
            rd_q[OFF_STAT] <= {rd_q[OFF_STAT][STAT_IRQ_BIT], 7'h10};
            rd_q[OFF_INTR] <= WHY_FUNC_DONE;
            rd_q[OFF_SEQ]  <= 8'h00;
          end
          if (act.resel_en) rd_q[OFF_INTR] <= 8'h00;
        end
      end
      // soft reset overrides every other update of this cycle
      if (soft_rst) begin
        for (int i = 0; i < NUM_REGS; i++) begin
          rd_q[i] <= 8'h00;
          wr_q[i] <= 8'h00;
        end
        rd_q[OFF_CFG1]   <= CFG1_INIT;
        rd_q[OFF_CNT_HI] <= CHIP_ID;
        dma_q            <= 1'b0;
        err_q            <= 1'b0;
      end
    end
  end

  assign rd_data  = rd_data_q;
  assign irq      = rd_q[OFF_STAT][STAT_IRQ_BIT];
  assign dma_mode = dma_q;
  assign cmd_err  = err_q;
endmodule

// File: rtl/ctl_regif_chk.sv
module ctl_regif_chk
  import ctl_regs_pkg::*;
#(
  parameter int ADDR_SHIFT = 2,
  localparam int BUS_AW = OFF_W + ADDR_SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [BUS_AW-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              irq,
  input logic              dma_mode,
  input logic              cmd_err
);
  logic [OFF_W-1:0] c_off;
  logic             c_cmd;
  assign c_off = OFF_W'(addr >> ADDR_SHIFT);
  assign c_cmd = wr_en && (c_off == OFF_CMD);

  // R7 also: only bus reset or message-accepted may raise the line
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(c_cmd && (wr_data[6:0] == OP_BUSRST ||
                                   wr_data[6:0] == OP_MSGACC)));

  assert_intr_read_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && c_off == OFF_INTR) |=> !irq);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cmd && wr_data[6:0] == OP_RESET) |=> (!irq && !dma_mode));

  assert_err_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(c_cmd));

  assert_dma_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cmd && wr_data[6:0] == OP_NOP) |=> (dma_mode == $past(wr_data[7])));

  assert_flush_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cmd && !rd_en && wr_data[6:0] == OP_FLUSH) |=> (irq == $past(irq)));
endmodule

bind ctl_regif ctl_regif_chk #(.ADDR_SHIFT(ADDR_SHIFT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wr_data  (wr_data),
  .irq      (irq),
  .dma_mode (dma_mode),
  .cmd_err  (cmd_err)
);

// File: tb/tb_ctl_regif.sv
module tb_ctl_regif;
  localparam int SHIFT = 2;
  localparam int AW    = 4 + SHIFT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          irq, dma_mode, cmd_err;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;
  logic [1:0] junk = 2'd0;
  logic rd_fire = 1'b0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  ctl_regif #(.ADDR_SHIFT(SHIFT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .dma_mode(dma_mode),
    .cmd_err(cmd_err)
  );

  always @(posedge clk) rd_fire <= rd_en;

  // monitor: R14 read data appears the cycle after the strobe
  always @(negedge clk) begin
    if (rd_fire) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R14 unexpected read data act=%h exp=none", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rd_data !== e.v) begin
          bad++;
          $display("FAIL %s read act=%h exp=%h", e.tag, rd_data, e.v);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    addr = {off, junk}; junk = junk + 2'd1;
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, input logic [7:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    addr = {off, junk}; junk = junk + 2'd1;
    e.v = v; e.tag = tag; sb.push_back(e);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values (offset 5 last: reading it moves the sequence step)
    chk("R1 irq", irq, 1'b0);
    chk("R1 dma", dma_mode, 1'b0);
    for (int i = 0; i < 16; i++)
      if (i != 5) rd(4'(i), (i == 8) ? 8'h07 : (i == 14) ? 8'h04 : 8'h00, "R1");
    rd(4'h5, 8'h00, "R1");
    // R2 / R13 mirrored offsets, junk low address bits rotate
    wr(4'hB, 8'hA5); rd(4'hB, 8'hA5, "R2");
    wr(4'hC, 8'h3C); rd(4'hC, 8'h3C, "R13");
    wr(4'h8, 8'h55); rd(4'h8, 8'h55, "R13");
    // R3 split registers
    wr(4'h4, 8'hFF); wr(4'h6, 8'hFF); wr(4'h7, 8'hFF); wr(4'h9, 8'hFF); wr(4'hA, 8'hFF);
    rd(4'h4, 8'h00, "R3"); rd(4'h6, 8'h04, "R3"); rd(4'h7, 8'h00, "R3");
    rd(4'h9, 8'h00, "R3"); rd(4'hA, 8'h00, "R3");
    wr(4'h0, 8'h12); wr(4'h1, 8'h34);
    rd(4'h0, 8'h00, "R3"); rd(4'h1, 8'h00, "R3");
    // R5 DMA qualifier
    wr(4'h3, 8'h80); chk("R5 dma set", dma_mode, 1'b1);
    rd(4'h0, 8'h12, "R5"); rd(4'h1, 8'h34, "R5"); rd(4'h3, 8'h80, "R13");
    wr(4'h0, 8'h99); wr(4'h3, 8'h00); chk("R5 dma clr", dma_mode, 1'b0);
    rd(4'h0, 8'h12, "R5");
    // R9 pad, then R4 destructive read
    wr(4'h3, 8'h18); chk("R9 irq", irq, 1'b0);
    rd(4'h4, 8'h10, "R9"); rd(4'h6, 8'h00, "R9"); rd(4'h5, 8'h08, "R9");
    rd(4'h4, 8'h00, "R4"); rd(4'h6, 8'h04, "R4");
    // R6 count write clears terminal count
    wr(4'h3, 8'h18); wr(4'h1, 8'h00);
    rd(4'h4, 8'h00, "R6"); rd(4'h5, 8'h08, "R6");
    // R10 message accepted
    wr(4'h3, 8'h12); chk("R10 irq", irq, 1'b1);
    rd(4'h4, 8'h80, "R10"); rd(4'h6, 8'h00, "R10"); rd(4'h7, 8'h00, "R10");
    rd(4'h5, 8'h20, "R10"); chk("R4 irq drop", irq, 1'b0);
    rd(4'h4, 8'h00, "R4");
    // R9 pad keeps pending interrupt
    wr(4'h3, 8'h12); wr(4'h3, 8'h18); chk("R9 irq kept", irq, 1'b1);
    rd(4'h4, 8'h90, "R9"); rd(4'h5, 8'h08, "R9"); chk("R4 irq", irq, 1'b0);
    // R7 bus reset, muted by cfg1 bit 6 (0x55 has it set)
    wr(4'h3, 8'h03); chk("R7 muted", irq, 1'b0); rd(4'h5, 8'h80, "R7");
    wr(4'h8, 8'h07); wr(4'h3, 8'h03); chk("R7 raised", irq, 1'b1);
    rd(4'h5, 8'h80, "R7"); chk("R7 ack", irq, 1'b0);
    // R8 flush keeps irq
    wr(4'h3, 8'h12); wr(4'h3, 8'h01); chk("R8 irq", irq, 1'b1);
    rd(4'h6, 8'h00, "R8"); rd(4'h7, 8'h00, "R8"); rd(4'h5, 8'h08, "R8");
    chk("R8 ack", irq, 1'b0);
    // R11 enable selection
    wr(4'h3, 8'h12); wr(4'h3, 8'h44); rd(4'h5, 8'h00, "R11"); chk("R11 ack", irq, 1'b0);
    // R12 unknown code
    wr(4'h3, 8'h25); chk("R12 err pulse", cmd_err, 1'b1);
    @(negedge clk); chk("R12 err single", cmd_err, 1'b0);
    rd(4'h3, 8'h25, "R12"); rd(4'h4, 8'h00, "R12");
    wr(4'h3, 8'h10); chk("R12 known no err", cmd_err, 1'b0); rd(4'h4, 8'h00, "R12");
    wr(4'h3, 8'hA5); chk("R12 dma untouched", dma_mode, 1'b0); rd(4'h0, 8'h12, "R12");
    // R11 soft reset
    wr(4'h3, 8'h92); chk("R5 dma msgacc", dma_mode, 1'b1); chk("R10 irq", irq, 1'b1);
    rd(4'h0, 8'h99, "R5");
    wr(4'h3, 8'h02); chk("R11 irq", irq, 1'b0); chk("R11 dma", dma_mode, 1'b0);
    rd(4'h8, 8'h07, "R11"); rd(4'hE, 8'h04, "R11"); rd(4'hB, 8'h00, "R11");
    rd(4'h0, 8'h00, "R11"); rd(4'h3, 8'h00, "R11"); rd(4'h6, 8'h00, "R11");
    repeat (3) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R14 pending reads act=%0d exp=0", sb.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule